// File: doc/BRIEF.md
# Sleep Interval Timer with Reference Buzz and Watchdog

This block times the wake-up intervals of a device that spends most of its life asleep. A free-running counter advances only on cycles where the slow-oscillator enable is high. When it completes the interval chosen by a 2-bit select, it issues a one-cycle wake pulse and starts again from zero. The same wraps feed a watchdog. If three wraps go by without a clear, the watchdog fires a one-cycle reset pulse, so its period is always three sleep intervals.

The block also decides whether the voltage reference and the reset-detect circuits are powered. While the device is awake they are always on. While it sleeps, they are normally off and are briefly powered for a fixed number of slow ticks each time a duty-cycle tick arrives. Two override bits change this with a fixed priority. The force bit keeps the reference on for the whole sleep. The disable bit keeps it off for the whole sleep, but only when the force bit is clear.

Top module: `sleep_buzz_timer`

## Requirements
- R1: The interval select picks the number of slow ticks per wake interval: 2'b00 gives 64, 2'b01 gives 512, 2'b10 gives 4096 and 2'b11 gives 32768. `wake_pulse` is high for exactly one cycle, in the cycle after the clock edge that carries the last slow tick of the interval.
- R2: Only cycles with `slow_tick_en` high advance the interval counter. Other cycles leave it unchanged.
- R3: Reset is synchronous and active high. It sets `wake_pulse` and `wdt_reset` to 0 and `ref_pwr_en` to 1, clears the interval counter and the wrap count, and sets the captured select to 2'b00.
- R4: Without a clear, `wdt_reset` pulses for one cycle on every third interval wrap, in the same cycle as that wrap's `wake_pulse`.
- R5: `wdt_clear` sets the wrap count to zero. If a clear arrives on the same edge as a wrap, the clear wins: no watchdog pulse, and the count restarts at zero.
- R6: While `asleep` is low, `ref_pwr_en` is 1, whatever the override bits are.
- R7: While asleep with both overrides clear, `ref_pwr_en` goes high on the edge that samples `duty_tick`. It stays high for BUZZ_TICKS slow ticks (4 by default). A new duty tick reloads the full width.
- R8: While asleep with `buzz_force_on` set, `ref_pwr_en` stays at 1 and duty ticks have no effect.
- R9: While asleep with `buzz_disable` set and `buzz_force_on` clear, `ref_pwr_en` stays at 0 and duty ticks have no effect.
- R10: `buzz_disable` has no effect while `buzz_force_on` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_tick_en | input | 1 | One-cycle enable per slow-oscillator period |
| asleep | input | 1 | Device is in sleep |
| ivl_sel | input | 2 | Wake interval select |
| buzz_disable | input | 1 | Keep reference off during sleep |
| buzz_force_on | input | 1 | Keep reference on during sleep (overrides disable) |
| duty_tick | input | 1 | Start of a reference power-up burst |
| wdt_clear | input | 1 | Watchdog clear |
| wake_pulse | output | 1 | One-cycle pulse at each interval wrap |
| ref_pwr_en | output | 1 | Reference and reset-detect power enable |
| wdt_reset | output | 1 | One-cycle watchdog expiry pulse |

## Verification
Each output is registered once. `wake_pulse` and `wdt_reset` therefore appear one cycle after the edge that carries the final slow tick. `ref_pwr_en` follows its inputs one edge later. The bench drives stimulus on falling edges, counts rising edges from the release of reset, and samples on the falling edge after the edge where a result is due. For example, the 64-tick interval is due 64 edges after reset, or 127 edges when the enable is present only on odd edges. Buzz widths are measured as the number of falling-edge samples with the enable high inside a fixed window.

// File: rtl/sbt_pkg.sv
package sbt_pkg;

    typedef enum logic [1:0] {
        IVL_SHORT = 2'b00,
        IVL_MED   = 2'b01,
        IVL_LONG  = 2'b10,
        IVL_MAX   = 2'b11
    } ivl_sel_e;

    typedef enum logic [1:0] {
        RP_AWAKE,
        RP_FORCED,
        RP_BLOCKED,
        RP_DUTY
    } ref_policy_e;

    typedef struct packed {
        logic asleep;
        logic no_buzz;
        logic dis_buzz;
    } slp_ctl_t;

    // log2 of the interval length for a select code
    function automatic int unsigned ivl_log2(ivl_sel_e s, int unsigned base, int unsigned step);
        return base + step * int'(s);
    endfunction

    // fixed priority: awake, then force-on, then disable, then duty bursts
    function automatic ref_policy_e pick_policy(slp_ctl_t c);
        if (!c.asleep)       return RP_AWAKE;
        else if (c.no_buzz)  return RP_FORCED;
        else if (c.dis_buzz) return RP_BLOCKED;
        else                 return RP_DUTY;
    endfunction

endpackage

// File: rtl/sbt_interval_ctr.sv
module sbt_interval_ctr
    import sbt_pkg::*;
#(
    parameter int unsigned BASE_LOG2 = 6,
    parameter int unsigned STEP_LOG2 = 3
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     tick_en_i,
    input  ivl_sel_e sel_i,
    output logic     wrap_o,
    output logic     wake_o
);
    localparam int unsigned CW = BASE_LOG2 + 3 * STEP_LOG2;

    ivl_sel_e      sel_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last_v;

    always_comb begin
        last_v = CW'((64'd1 << ivl_log2(sel_q, BASE_LOG2, STEP_LOG2)) - 64'd1);
        // >= lets a shrunk select wrap at once instead of running past
        wrap_o = tick_en_i && (cnt_q >= last_v);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q  <= IVL_SHORT;
            cnt_q  <= '0;
            wake_o <= 1'b0;
        end else begin
            sel_q  <= sel_i;
            wake_o <= wrap_o;
            if (wrap_o)
                cnt_q <= '0;
            else if (tick_en_i)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_WAKE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        wake_o |=> !wake_o);                                    // R1
    AST_WAKE_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
        wake_o |-> $past(tick_en_i));                           // R2
    AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !tick_en_i |=> $stable(cnt_q));                         // R2

endmodule

// File: rtl/sbt_watchdog.sv
module sbt_watchdog #(
    parameter int unsigned WRAPS = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic wrap_i,
    input  logic clear_i,
    output logic expire_o
);
    localparam int unsigned WW = $clog2(WRAPS + 1);
    localparam logic [WW-1:0] LAST = WW'(WRAPS - 1);

    logic [WW-1:0] wcnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wcnt_q   <= '0;
            expire_o <= 1'b0;
        end else begin
            expire_o <= 1'b0;
            if (clear_i) begin
                wcnt_q <= '0;
            end else if (wrap_i) begin
                if (wcnt_q == LAST) begin
                    wcnt_q   <= '0;
                    expire_o <= 1'b1;
                end else begin
                    wcnt_q <= wcnt_q + 1'b1;
                end
            end
        end
    end

    AST_CLEAR_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(clear_i) |-> !expire_o);                          // R5
    AST_EXPIRE_NEEDS_WRAP: assert property (@(posedge clk) disable iff (rst)
        expire_o |-> $past(wrap_i));                            // R4

endmodule

// File: rtl/sbt_ref_power.sv
module sbt_ref_power
    import sbt_pkg::*;
#(
    parameter int unsigned BUZZ_TICKS = 4
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     tick_en_i,
    input  slp_ctl_t ctl_i,
    input  logic     duty_tick_i,
    output logic     ref_en_o
);
    localparam int unsigned BW = $clog2(BUZZ_TICKS + 1);

    logic [BW-1:0] bz_q, bz_d;
    ref_policy_e   pol;
    logic          ref_d;

    always_comb begin
        pol  = pick_policy(ctl_i);
        bz_d = bz_q;
        if (!ctl_i.asleep)
            bz_d = '0;
        else if (duty_tick_i)
            bz_d = BW'(BUZZ_TICKS);
        else if (tick_en_i && bz_q != '0)
            bz_d = bz_q - 1'b1;

        case (pol)
            RP_AWAKE, RP_FORCED: ref_d = 1'b1;
            RP_BLOCKED:          ref_d = 1'b0;
            default:             ref_d = (bz_d != '0);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bz_q     <= '0;
            ref_en_o <= 1'b1;
        end else begin
            bz_q     <= bz_d;
            ref_en_o <= ref_d;
        end
    end

    AST_AWAKE_ON: assert property (@(posedge clk) disable iff (rst)
        !$past(ctl_i.asleep) |-> ref_en_o);                     // R6
    AST_FORCE_ON: assert property (@(posedge clk) disable iff (rst)
        $past(ctl_i.asleep && ctl_i.no_buzz) |-> ref_en_o);     // R8
    AST_BLOCK_OFF: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(ctl_i.asleep && ctl_i.dis_buzz && !ctl_i.no_buzz))
        |-> !ref_en_o);                                         // R9
    AST_DUTY_START: assert property (@(posedge clk) disable iff (rst)
        $past(ctl_i.asleep && !ctl_i.no_buzz && !ctl_i.dis_buzz && duty_tick_i)
        |-> ref_en_o);                                          // R7

endmodule

// File: rtl/sleep_buzz_timer.sv
module sleep_buzz_timer
    import sbt_pkg::*;
#(
    parameter int unsigned BASE_LOG2  = 6,
    parameter int unsigned STEP_LOG2  = 3,
    parameter int unsigned WDT_WRAPS  = 3,
    parameter int unsigned BUZZ_TICKS = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       slow_tick_en,
    input  logic       asleep,
    input  logic [1:0] ivl_sel,
    input  logic       buzz_disable,
    input  logic       buzz_force_on,
    input  logic       duty_tick,
    input  logic       wdt_clear,
    output logic       wake_pulse,
    output logic       ref_pwr_en,
    output logic       wdt_reset
);
    logic     wrap;
    slp_ctl_t ctl;

    assign ctl = '{asleep: asleep, no_buzz: buzz_force_on, dis_buzz: buzz_disable};

    sbt_interval_ctr #(
        .BASE_LOG2(BASE_LOG2),
        .STEP_LOG2(STEP_LOG2)
    ) u_ivl (
        .clk      (clk),
        .rst      (rst),
        .tick_en_i(slow_tick_en),
        .sel_i    (ivl_sel_e'(ivl_sel)),
        .wrap_o   (wrap),
        .wake_o   (wake_pulse)
    );

    sbt_watchdog #(
        .WRAPS(WDT_WRAPS)
    ) u_wdt (
        .clk     (clk),
        .rst     (rst),
        .wrap_i  (wrap),
        .clear_i (wdt_clear),
        .expire_o(wdt_reset)
    );

    sbt_ref_power #(
        .BUZZ_TICKS(BUZZ_TICKS)
    ) u_ref (
        .clk        (clk),
        .rst        (rst),
        .tick_en_i  (slow_tick_en),
        .ctl_i      (ctl),
        .duty_tick_i(duty_tick),
        .ref_en_o   (ref_pwr_en)
    );

    AST_WDT_ON_WAKE: assert property (@(posedge clk) disable iff (rst)
        wdt_reset |-> wake_pulse);                              // R4

endmodule

// File: tb/sleep_buzz_timer_tb.sv
module sleep_buzz_timer_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       slow_tick_en = 1'b1;
    logic       asleep = 1'b0;
    logic [1:0] ivl_sel = 2'b00;
    logic       buzz_disable = 1'b0;
    logic       buzz_force_on = 1'b0;
    logic       duty_tick = 1'b0;
    logic       wdt_clear = 1'b0;
    logic       wake_pulse, ref_pwr_en, wdt_reset;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    sleep_buzz_timer u_dut (
        .clk(clk), .rst(rst), .slow_tick_en(slow_tick_en), .asleep(asleep),
        .ivl_sel(ivl_sel), .buzz_disable(buzz_disable), .buzz_force_on(buzz_force_on),
        .duty_tick(duty_tick), .wdt_clear(wdt_clear),
        .wake_pulse(wake_pulse), .ref_pwr_en(ref_pwr_en), .wdt_reset(wdt_reset)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // edges until the next wake pulse; gated drives the enable on odd edges only
    task automatic next_wake(input bit gated, output int n, output bit wd);
        n = 0;
        do begin
            if (gated) slow_tick_en = (n % 2 == 0);
            @(posedge clk);
            n++;
            @(negedge clk);
        end while (!wake_pulse && n < 40000);
        wd = wdt_reset;
        slow_tick_en = 1'b1;
    endtask

    // 12-cycle window, duty ticks before edges t0 and t1; returns samples with ref high
    task automatic buzz_window(input int t0, input int t1, output int hi);
        hi = 0;
        for (int i = 0; i < 12; i++) begin
            duty_tick = (i == t0) || (i == t1);
            @(negedge clk);
            if (ref_pwr_en) hi++;
        end
        duty_tick = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run hung, actual 0 expected 1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int  n, hi;
        bit  wd;

        // R3 reset state
        ivl_sel = 2'b11;
        do_reset();
        check(wake_pulse == 1'b0, "R3 wake", wake_pulse, 0);
        check(wdt_reset == 1'b0, "R3 wdt", wdt_reset, 0);
        check(ref_pwr_en == 1'b1, "R3 ref", ref_pwr_en, 1);

        // R1 interval sweep over every select code
        for (int s = 0; s < 4; s++) begin
            int exp_len;
            exp_len = 64 << (3 * s);
            ivl_sel = 2'(s);
            do_reset();
            next_wake(1'b0, n, wd);
            check(n == exp_len, "R1 first interval", n, exp_len);
            next_wake(1'b0, n, wd);
            check(n == exp_len, "R1 repeat interval", n, exp_len);
        end

        // R2 enable on odd edges only: 64th tick lands on edge 127
        ivl_sel = 2'b00;
        do_reset();
        next_wake(1'b1, n, wd);
        check(n == 127, "R2 gated interval", n, 127);

        // R4 watchdog on every third wrap
        do_reset();
        for (int w = 1; w <= 6; w++) begin
            next_wake(1'b0, n, wd);
            check(wd == (w % 3 == 0), "R4 wdt at wrap", wd, int'(w % 3 == 0));
        end

        // R5 clear between wraps restarts the count
        do_reset();
        next_wake(1'b0, n, wd);
        next_wake(1'b0, n, wd);
        repeat (20) @(negedge clk);
        wdt_clear = 1'b1;
        @(negedge clk);
        wdt_clear = 1'b0;
        for (int w = 3; w <= 5; w++) begin
            next_wake(1'b0, n, wd);
            check(wd == (w == 5), "R5 wdt after clear", wd, int'(w == 5));
        end

        // R5 clear on the wrap edge wins
        do_reset();
        next_wake(1'b0, n, wd);
        next_wake(1'b0, n, wd);
        repeat (63) @(negedge clk);
        wdt_clear = 1'b1;
        @(negedge clk);
        wdt_clear = 1'b0;
        check(wake_pulse == 1'b1, "R5 wrap with clear wake", wake_pulse, 1);
        check(wdt_reset == 1'b0, "R5 wrap with clear wdt", wdt_reset, 0);
        for (int w = 1; w <= 3; w++) begin
            next_wake(1'b0, n, wd);
            check(wd == (w == 3), "R5 count after clear-on-wrap", wd, int'(w == 3));
        end

        // R7 duty bursts
        do_reset();
        asleep = 1'b1;
        @(negedge clk);
        check(ref_pwr_en == 1'b0, "R7 idle sleep", ref_pwr_en, 0);
        buzz_window(0, 99, hi);
        check(hi == 4, "R7 burst width", hi, 4);
        buzz_window(0, 2, hi);
        check(hi == 6, "R7 retrigger width", hi, 6);

        // R8 force on
        buzz_force_on = 1'b1;
        buzz_window(3, 7, hi);
        check(hi == 12, "R8 forced on", hi, 12);

        // R10 disable ignored under force
        buzz_disable = 1'b1;
        buzz_window(1, 5, hi);
        check(hi == 12, "R10 disable under force", hi, 12);

        // R9 disable alone blocks bursts
        buzz_force_on = 1'b0;
        buzz_window(1, 5, hi);
        check(hi == 0, "R9 blocked", hi, 0);

        // R6 awake overrides disable
        asleep = 1'b0;
        buzz_window(0, 99, hi);
        check(hi == 12, "R6 awake on", hi, 12);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule